// File: doc/BRIEF.md
# Attack/Hold Pulse Timer

This block shapes a two-stage drive pulse for an actuator or note generator. A trigger raises the attack output and starts an interval. The interval is made of a programmable number of long periods of 256 ticks each, then one short period whose length is programmable. All periods count ticks from a clock divider that a prescale code selects. When the interval ends, the attack output falls. The hold output then either goes high and stays high, or carries a duty-cycle waveform. In repeat mode the block does neither of those: it restarts the interval by itself, so the attack output becomes a square wave while the hold output carries the waveform.

The configuration inputs are live levels. The interval counters compare against them on every tick. A stop strobe releases the hold output. It does not touch the interval timer.

Top module: `note_pulse_timer`

## Requirements
- R1: A trigger drives attack high on the next clock edge and restarts the interval. For a coarse count C and a fine value F, the interval lasts 256*C + F + 1 ticks. When C is 0 the long periods are skipped.
- R2: Prescale codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. The divider restarts on the trigger, so the first tick comes one divider period after the trigger edge.
- R3: Prescale code 0 stops ticking and freezes an active interval. Codes 6 and 7 divide by 1024.
- R4: When the interval ends and mode bit 0 is clear, attack goes low and the timer goes idle. If mode bit 1 is also clear, hold goes high and stays high.
- R5: When the interval ends and mode bit 1 is set (bit 0 clear), hold carries the waveform. The waveform goes high on the clock where its free-running counter wraps at the top value. It goes low on the clock where the counter equals the duty value. For duty < top this gives duty+1 high clocks in every top+1 clocks.
- R6: With mode bit 0 set, the end of each interval restarts the interval, inverts attack and turns the hold waveform on.
- R7: A stop strobe forces hold low from the next edge and turns the waveform off. An active interval and the attack output are unaffected.
- R8: A trigger during an active interval restarts the full interval from that trigger.
- R9: The state output shows attack in bit 0. Bit 1 is high while hold is steady or carrying the waveform.
- R10: After reset, attack, hold and state are all zero and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start or restart the interval |
| stop_i | input | 1 | Release hold |
| coarse_i | input | 8 | Number of 256-tick periods |
| fine_i | input | 8 | Fine period compare value |
| prescale_i | input | 3 | Tick divider code |
| mode_i | input | 2 | Bit 0 repeat, bit 1 waveform hold |
| pwm_duty_i | input | 8 | Waveform clear point |
| pwm_top_i | input | 8 | Waveform counter wrap value |
| attack_o | output | 1 | Attack drive |
| hold_o | output | 1 | Hold drive |
| state_o | output | 2 | {hold active, attack} |

## Verification
The hardest situations to reach are the handover from the long periods to the fine period, and the end of repeat operation. To reach the handover, the bench uses coarse counts of 1 and 2 with small fine values at the fastest divider, so the exact edge where attack falls shows any miscount in the long periods. To reach the end of repeat operation, the bench changes the mode bits while the block is already free-running. It then checks that the next interval end leaves attack low and hold steady. Frozen ticks are reached by selecting code 0 after a trigger and then switching to a running code.

// File: rtl/np_pkg.sv
package np_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_COARSE, PH_FINE} phase_e;
  typedef enum logic [1:0] {HM_OFF, HM_STEADY, HM_PWM} hold_e;

  // log2 of the tick divider for a prescale code (codes above 5 saturate)
  function automatic int unsigned div_shift(input logic [2:0] code);
    case (code)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/np_prescaler.sv
module np_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);
  import np_pkg::*;

  logic [DIV_W-1:0] cnt_q, cnt_d, limit;
  logic             run;

  always_comb begin
    run    = (code_i != 3'd0);
    limit  = DIV_W'((1 << div_shift(code_i)) - 1);
    tick_o = run && (cnt_q >= limit);
    if (clr_i)        cnt_d = '0;
    else if (!run)    cnt_d = cnt_q;
    else if (tick_o)  cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/np_interval.sv
module np_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] coarse_i,
  input  logic [CNT_W-1:0] fine_i,
  input  logic             repeat_i,
  input  logic             pwm_mode_i,
  output logic             attack_o,
  output logic             req_steady_o,
  output logic             req_pwm_o
);
  import np_pkg::*;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d, pcnt_q, pcnt_d, lim;
  logic             attack_q, attack_d, match;
  phase_e           start_ph;

  always_comb begin
    start_ph     = (coarse_i != '0) ? PH_COARSE : PH_FINE;
    lim          = (phase_q == PH_COARSE) ? {CNT_W{1'b1}} : fine_i;
    match        = tick_i && (phase_q != PH_IDLE) && (tcnt_q == lim);
    phase_d      = phase_q;
    tcnt_d       = tcnt_q;
    pcnt_d       = pcnt_q;
    attack_d     = attack_q;
    req_steady_o = 1'b0;
    req_pwm_o    = 1'b0;
    if (trig_i) begin
      phase_d  = start_ph;
      tcnt_d   = '0;
      pcnt_d   = '0;
      attack_d = 1'b1;
    end else if (tick_i && phase_q != PH_IDLE) begin
      if (!match) begin
        tcnt_d = tcnt_q + 1'b1;
      end else begin
        tcnt_d = '0;
        if (phase_q == PH_COARSE) begin
          pcnt_d = pcnt_q + 1'b1;
          if ({1'b0, pcnt_q} + 1'b1 >= {1'b0, coarse_i}) phase_d = PH_FINE;
        end else if (repeat_i) begin
          phase_d   = start_ph;
          pcnt_d    = '0;
          attack_d  = ~attack_q;
          req_pwm_o = 1'b1;
        end else begin
          phase_d  = PH_IDLE;
          attack_d = 1'b0;
          if (pwm_mode_i) req_pwm_o    = 1'b1;
          else            req_steady_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      tcnt_q   <= '0;
      pcnt_q   <= '0;
      attack_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      tcnt_q   <= tcnt_d;
      pcnt_q   <= pcnt_d;
      attack_q <= attack_d;
    end
  end

  assign attack_o = attack_q;

  // R4
  idle_no_attack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !attack_q);
endmodule

// File: rtl/np_hold.sv
module np_hold #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             req_steady_i,
  input  logic             req_pwm_i,
  input  logic [PWM_W-1:0] duty_i,
  input  logic [PWM_W-1:0] top_i,
  output logic             hold_o,
  output logic             active_o
);
  import np_pkg::*;

  hold_e            hmode_q, hmode_d;
  logic [PWM_W-1:0] pcnt_q, pcnt_d;
  logic             level_q, level_d;

  always_comb begin
    hmode_d = hmode_q;
    if (stop_i)            hmode_d = HM_OFF;
    else if (req_pwm_i)    hmode_d = HM_PWM;
    else if (req_steady_i) hmode_d = HM_STEADY;

    level_d = level_q;
    if (pcnt_q == top_i) begin
      pcnt_d  = '0;
      level_d = 1'b1;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
      if (pcnt_q == duty_i) level_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hmode_q <= HM_OFF;
      pcnt_q  <= '0;
      level_q <= 1'b0;
    end else begin
      hmode_q <= hmode_d;
      pcnt_q  <= pcnt_d;
      level_q <= level_d;
    end
  end

  assign hold_o   = (hmode_q == HM_STEADY) || ((hmode_q == HM_PWM) && level_q);
  assign active_o = (hmode_q != HM_OFF);

  // R5
  wrap_sets_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt_q == top_i) |=> level_q);
endmodule

// File: rtl/note_pulse_timer.sv
module note_pulse_timer #(
  parameter int CNT_W = 8,
  parameter int PWM_W = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] coarse_i,
  input  logic [CNT_W-1:0] fine_i,
  input  logic [2:0]       prescale_i,
  input  logic [1:0]       mode_i,
  input  logic [PWM_W-1:0] pwm_duty_i,
  input  logic [PWM_W-1:0] pwm_top_i,
  output logic             attack_o,
  output logic             hold_o,
  output logic [1:0]       state_o
);
  logic tick, req_steady, req_pwm, hold_active;

  np_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr_i(trig_i), .code_i(prescale_i), .tick_o(tick)
  );

  np_interval #(.CNT_W(CNT_W)) u_intv (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .tick_i(tick),
    .coarse_i(coarse_i), .fine_i(fine_i),
    .repeat_i(mode_i[0]), .pwm_mode_i(mode_i[1]),
    .attack_o(attack_o), .req_steady_o(req_steady), .req_pwm_o(req_pwm)
  );

  np_hold #(.PWM_W(PWM_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i),
    .req_steady_i(req_steady), .req_pwm_i(req_pwm),
    .duty_i(pwm_duty_i), .top_i(pwm_top_i),
    .hold_o(hold_o), .active_o(hold_active)
  );

  assign state_o = {hold_active, attack_o};

  // R1
  trig_raises_attack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> attack_o);
  // R7
  stop_drops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !hold_o);
endmodule

// File: tb/note_pulse_timer_bench.sv
module note_pulse_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0, stop = 1'b0;
  logic [7:0] coarse = '0, fine = '0, duty = 8'd4, top = 8'd9;
  logic [2:0] presc = 3'd1;
  logic [1:0] mode = '0;
  logic       attack, hold;
  logic [1:0] state;
  int         checks = 0, fails = 0;

  always #2 clk = ~clk;

  note_pulse_timer u_note_pulse_timer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .stop_i(stop),
    .coarse_i(coarse), .fine_i(fine), .prescale_i(presc), .mode_i(mode),
    .pwm_duty_i(duty), .pwm_top_i(top),
    .attack_o(attack), .hold_o(hold), .state_o(state)
  );

  // vector table: coarse, fine, prescale code, mode
  localparam int NV = 7;
  localparam int VC[NV] = '{0, 1, 0, 2, 0, 0, 0};
  localparam int VF[NV] = '{3, 2, 5, 0, 2, 0, 1};
  localparam int VP[NV] = '{1, 1, 2, 1, 3, 6, 7};
  localparam int VM[NV] = '{0, 0, 0, 2, 2, 0, 2};

  function automatic int divider(input int code);
    case (code)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      default: return 1024;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (attack == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int hi;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(attack, 0, "R10 attack");
    check(hold, 0, "R10 hold");
    check(state, 0, "R10 state");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      coarse = 8'(VC[v]); fine = 8'(VF[v]); presc = 3'(VP[v]); mode = 2'(VM[v]);
      pulse_trig();
      check(attack, 1, "R1 attack after trigger");
      run_len(1'b1, n);
      // R1 R2 R3 length in clocks
      check(n, divider(VP[v]) * (256 * VC[v] + VF[v] + 1), "R1/R2 interval length");
      if (VM[v] == 0) begin
        check(hold, 1, "R4 steady hold");
        check(state, 2, "R9 state after steady");
      end else begin
        check(state, 2, "R9 state after pwm");
        hi = 0;
        for (int k = 0; k < 10; k++) begin
          if (hold) hi++;
          @(negedge clk);
        end
        check(hi, 5, "R5 pwm high clocks");
      end
      pulse_stop();
      check(hold, 0, "R7 hold after stop");
      check(state, 0, "R9 state after stop");
    end

    // R3 code 0 freezes ticking
    presc = 3'd0; fine = 8'd0; coarse = 8'd0; mode = 2'd0;
    pulse_trig();
    repeat (50) @(negedge clk);
    check(attack, 1, "R3 frozen attack");
    presc = 3'd1;
    repeat (5) @(negedge clk);
    check(attack, 0, "R3 resumes");
    pulse_stop();

    // R8 retrigger, R7 stop leaves attack alone
    fine = 8'd20;
    pulse_trig();
    repeat (5) @(negedge clk);
    pulse_stop();
    check(attack, 1, "R7 attack unaffected by stop");
    repeat (3) @(negedge clk);
    pulse_trig();
    run_len(1'b1, n);
    check(n, 21, "R8 retrigger length");
    pulse_stop();

    // R6 repeat mode
    fine = 8'd3; mode = 2'd1;
    pulse_trig();
    run_len(1'b1, n);
    check(n, 4, "R6 first high");
    run_len(1'b0, n);
    check(n, 4, "R6 low phase");
    check(state[1], 1, "R6 pwm hold running");
    mode = 2'd0;
    run_len(1'b1, n);
    check(n, 4, "R6 last high");
    repeat (10) @(negedge clk);
    check(attack, 0, "R4 stays idle after repeat off");
    check(hold, 1, "R4 steady after repeat off");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule